// File: doc/BRIEF.md
# Queue Interrupt Condition Controller

This block gathers interrupt conditions for the queues of a packet DMA engine: a set of receive queues and a set of transmit queues, sixteen of each by default. The engine pulses per-queue receive events. It also reports transmit progress by posting a 32-bit completion-pointer value for a queue. Both kinds of event latch a status bit, and the block raises a single interrupt line whenever any status bit is set.

Software reaches the block through a simple register port. A receive condition is dismissed by writing ones to the receive clear register. A transmit condition is not dismissed that way. Software first reclaims its buffer descriptors, then writes the queue's completion-pointer register. The status bit drops only when the written value equals the value the engine last posted for that queue. Read data is registered and returned one cycle after the read strobe.

Address map (byte offsets): receive status 0x240, receive clear 0x248, transmit status 0x250, transmit clear 0x258. Queue q's completion-pointer register sits at 0x300 + 4*q. In the status and clear registers, bit q stands for queue q, and bits 31..16 read as zero.

Top module: `qic_top`

## Requirements
- R1: After reset every status bit is 0, `irq` is 0 and `reg_rdata` is 0.
- R2: A 1 on `rx_evt[q]` in a cycle sets receive status bit q, which reads back at 0x240 bit q; bits above the queue count read as 0.
- R3: A write to 0x248 clears every receive status bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R4: When a set event and a software clear hit the same status bit in the same cycle, the bit ends up set. This holds for a receive event against a 0x248 write, and for an engine pointer post against a matching pointer write.
- R5: A cycle with `port_cp_vld` high sets transmit status bit `port_cp_q`, readable at 0x250. It also stores `port_cp_val`, which reads back at 0x300 + 4*`port_cp_q`.
- R6: A software write to 0x300 + 4*q whose data equals the stored value for queue q clears transmit status bit q.
- R7: A software write to 0x300 + 4*q whose data differs from the stored value leaves transmit status bit q set.
- R8: A write to the transmit clear register 0x258 has no effect on the transmit status.
- R9: Reads of 0x248 and 0x258 return 0.
- R10: `irq` equals the OR of all receive and transmit status bits as they were one cycle earlier.
- R11: `reg_rdata` changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW (12) | Register byte address |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Registered read data |
| rx_evt | input | NQ (16) | Per-queue receive condition events |
| port_cp_vld | input | 1 | Engine completion-pointer post strobe |
| port_cp_q | input | QW (4) | Queue index of the post |
| port_cp_val | input | PW (32) | Completion-pointer value posted |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The bench aims at the same-cycle collisions. A design where the clear wins would lose a condition that arrives while software is acknowledging, and the bit would read back as 0. It writes mismatched pointer values and the transmit clear register. A design that treated either as an acknowledge would drop a transmit bit before its descriptors were reclaimed. It times `irq` to the exact cycle, because a combinational or two-stage output would show up one cycle early or late. It also checks that the clear registers read as 0, that the highest queue index decodes correctly, and that the read data holds between strobes.

// File: rtl/qic_pkg.sv
package qic_pkg;
   localparam int RX_STAT_OFS = 'h240;
   localparam int RX_CLR_OFS  = 'h248;
   localparam int TX_STAT_OFS = 'h250;
   localparam int TX_CLR_OFS  = 'h258;
   localparam int CP_BASE_OFS = 'h300;

   typedef enum logic [1:0] {
      RSEL_ZERO,
      RSEL_RXS,
      RSEL_TXS,
      RSEL_CP
   } rsel_e;
endpackage

// File: rtl/qic_regdec.sv
module qic_regdec #(
   parameter int AW = 12,
   parameter int NQ = 16,
   parameter int QW = 4
) (
   input  logic [AW-1:0]  addr,
   input  logic           wr,
   output qic_pkg::rsel_e rsel,
   output logic           rx_clr_we,
   output logic           cp_we,
   output logic [QW-1:0]  cp_idx
);
   import qic_pkg::*;

   localparam logic [AW-1:0] A_RXS = AW'(RX_STAT_OFS);
   localparam logic [AW-1:0] A_RXC = AW'(RX_CLR_OFS);
   localparam logic [AW-1:0] A_TXS = AW'(TX_STAT_OFS);
   localparam logic [AW-1:0] A_CP0 = AW'(CP_BASE_OFS);
   localparam logic [AW-1:0] A_CPN = AW'(CP_BASE_OFS + 4*NQ);

   logic [AW-1:0] offs;
   logic          cp_hit;

   assign offs   = addr - A_CP0;
   assign cp_hit = (addr >= A_CP0) && (addr < A_CPN) && (addr[1:0] == 2'b00);

   generate
      if (NQ == 1) begin : g_one
         assign cp_idx = '0;
      end else begin : g_many
         assign cp_idx = offs[2 +: QW];
      end
   endgenerate

   assign rx_clr_we = wr && (addr == A_RXC);
   assign cp_we     = wr && cp_hit;

   always_comb begin
      if (addr == A_RXS)      rsel = RSEL_RXS;
      else if (addr == A_TXS) rsel = RSEL_TXS;
      else if (cp_hit)        rsel = RSEL_CP;
      else                    rsel = RSEL_ZERO;
   end
endmodule

// File: rtl/qic_rx_bank.sv
module qic_rx_bank #(
   parameter int NQ = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NQ-1:0] set,
   input  logic          clr_we,
   input  logic [NQ-1:0] clr_mask,
   output logic [NQ-1:0] stat
);
   logic [NQ-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr_eff) | set;
   end
endmodule

// File: rtl/qic_tx_bank.sv
module qic_tx_bank #(
   parameter int NQ = 16,
   parameter int PW = 32,
   parameter int QW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          port_vld,
   input  logic [QW-1:0] port_q,
   input  logic [PW-1:0] port_val,
   input  logic          sw_we,
   input  logic [QW-1:0] sw_q,
   input  logic [PW-1:0] sw_val,
   input  logic [QW-1:0] rd_q,
   output logic [PW-1:0] rd_val,
   output logic [NQ-1:0] stat
);
   logic [PW-1:0] cp_mem [NQ];

   generate
      for (genvar i = 0; i < NQ; i++) begin : g_q
         logic post_hit, ack_hit;
         assign post_hit = port_vld && (port_q == QW'(i));
         assign ack_hit  = sw_we && (sw_q == QW'(i)) && (sw_val == cp_mem[i]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cp_mem[i] <= '0;
               stat[i]   <= 1'b0;
            end else if (post_hit) begin
               cp_mem[i] <= port_val;
               stat[i]   <= 1'b1;
            end else if (ack_hit) begin
               stat[i]   <= 1'b0;
            end
         end
      end
   endgenerate

   assign rd_val = cp_mem[rd_q];
endmodule

// File: rtl/qic_top.sv
module qic_top #(
   parameter int AW = 12,
   parameter int DW = 32,
   parameter int NQ = 16,
   parameter int PW = 32,
   localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic [NQ-1:0] rx_evt,
   input  logic          port_cp_vld,
   input  logic [QW-1:0] port_cp_q,
   input  logic [PW-1:0] port_cp_val,
   output logic          irq
);
   import qic_pkg::*;

   generate
      if (NQ < 1 || NQ > 16) begin : g_bad_nq
         $error("qic_top: NQ must be 1..16");
      end
      if (DW < PW || PW < 1) begin : g_bad_pw
         $error("qic_top: PW must be 1..DW");
      end
      if (CP_BASE_OFS + 4*NQ > (1 << AW)) begin : g_bad_aw
         $error("qic_top: AW too small for the pointer window");
      end
   endgenerate

   rsel_e         rsel;
   logic          rx_clr_we, cp_we;
   logic [QW-1:0] cp_idx;
   logic [NQ-1:0] rx_stat, tx_stat;
   logic [PW-1:0] cp_rd_val;
   logic [DW-1:0] rd_mux;

   qic_regdec #(.AW(AW), .NQ(NQ), .QW(QW)) u_dec (
      .addr(reg_addr), .wr(reg_wr), .rsel(rsel),
      .rx_clr_we(rx_clr_we), .cp_we(cp_we), .cp_idx(cp_idx)
   );

   qic_rx_bank #(.NQ(NQ)) u_rx (
      .clk(clk), .rst_n(rst_n), .set(rx_evt),
      .clr_we(rx_clr_we), .clr_mask(reg_wdata[NQ-1:0]), .stat(rx_stat)
   );

   qic_tx_bank #(.NQ(NQ), .PW(PW), .QW(QW)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .port_vld(port_cp_vld), .port_q(port_cp_q), .port_val(port_cp_val),
      .sw_we(cp_we), .sw_q(cp_idx), .sw_val(reg_wdata[PW-1:0]),
      .rd_q(cp_idx), .rd_val(cp_rd_val), .stat(tx_stat)
   );

   always_comb begin
      unique case (rsel)
         RSEL_RXS: rd_mux = DW'(rx_stat);
         RSEL_TXS: rd_mux = DW'(tx_stat);
         RSEL_CP:  rd_mux = DW'(cp_rd_val);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         irq       <= 1'b0;
      end else begin
         if (reg_rd) reg_rdata <= rd_mux;
         irq <= |{rx_stat, tx_stat};
      end
   end
endmodule

// File: rtl/qic_chk.sv
module qic_chk #(
   parameter int AW = 12,
   parameter int DW = 32,
   parameter int NQ = 16,
   parameter int QW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic [AW-1:0] reg_addr,
   input logic [DW-1:0] reg_wdata,
   input logic [DW-1:0] reg_rdata,
   input logic [NQ-1:0] rx_evt,
   input logic          port_cp_vld,
   input logic [QW-1:0] port_cp_q,
   input logic          irq,
   input logic [NQ-1:0] rx_stat,
   input logic [NQ-1:0] tx_stat
);
   localparam logic [AW-1:0] A_RXC = AW'(qic_pkg::RX_CLR_OFS);
   localparam logic [AW-1:0] A_TXC = AW'(qic_pkg::TX_CLR_OFS);

   p_rx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt != '0) |=> ((rx_stat & $past(rx_evt)) == $past(rx_evt)));

   p_rx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_RXC && rx_evt == '0)
      |=> ((rx_stat & $past(reg_wdata[NQ-1:0])) == '0));

   p_port_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      port_cp_vld |=> tx_stat[$past(port_cp_q)]);

   p_txclr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_TXC)
      |=> ((tx_stat & $past(tx_stat)) == $past(tx_stat)));

   p_clr_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (reg_addr == A_RXC || reg_addr == A_TXC)) |=> (reg_rdata == '0));

   p_irq_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|{rx_stat, tx_stat}) |=> irq);

   p_irq_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(|{rx_stat, tx_stat}) |=> !irq);

   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));
endmodule

bind qic_top qic_chk #(.AW(AW), .DW(DW), .NQ(NQ), .QW(QW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .rx_evt(rx_evt), .port_cp_vld(port_cp_vld), .port_cp_q(port_cp_q),
   .irq(irq), .rx_stat(rx_stat), .tx_stat(tx_stat)
);

// File: tb/tb_qic_top.sv
module tb_qic_top;
   localparam int AW = 12, DW = 32, NQ = 16, PW = 32, QW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NQ-1:0] rx_evt = '0;
   logic          port_cp_vld = 1'b0;
   logic [QW-1:0] port_cp_q = '0;
   logic [PW-1:0] port_cp_val = '0;
   logic          irq;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   qic_top dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_evt(rx_evt), .port_cp_vld(port_cp_vld), .port_cp_q(port_cp_q),
      .port_cp_val(port_cp_val), .irq(irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      reg_wr = 0; reg_rd = 0; rx_evt = '0; port_cp_vld = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_rd = 1; reg_wr = 0; reg_addr = a;
      @(negedge clk);
      reg_rd = 0;
      v = reg_rdata;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_rd = 0; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic post(input int q, input logic [31:0] v);
      @(negedge clk);
      port_cp_vld = 1; port_cp_q = QW'(q); port_cp_val = v;
      @(negedge clk);
      port_cp_vld = 0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 irq", 32'(irq), 0);
      check("R1 rdata", reg_rdata, 0);
      rd(12'h240, v); check("R1 rx status", v, 0);
      rd(12'h250, v); check("R1 tx status", v, 0);
   endtask

   task automatic t_rx_set_clear();
      logic [31:0] v;
      @(negedge clk); rx_evt = 16'h8001;
      @(negedge clk); rx_evt = '0;
      check("R10 irq not yet", 32'(irq), 0);
      @(negedge clk);
      check("R10 irq one cycle later", 32'(irq), 1);
      rd(12'h240, v); check("R2 rx status", v, 32'h0000_8001);
      wr(12'h248, 32'h0000_0001);
      rd(12'h240, v); check("R3 partial clear", v, 32'h0000_8000);
      rd(12'h248, v); check("R9 rx clear reads zero", v, 0);
      wr(12'h248, 32'hFFFF_8000);
      rd(12'h240, v); check("R3 full clear", v, 0);
      check("R10 irq dropped", 32'(irq), 0);
   endtask

   task automatic t_rx_collide();
      logic [31:0] v;
      @(negedge clk);
      rx_evt = 16'h0008; reg_wr = 1; reg_addr = 12'h248; reg_wdata = 32'h0000_0008;
      idle();
      rd(12'h240, v); check("R4 rx set wins", v, 32'h0000_0008);
      wr(12'h248, 32'h0000_0008);
   endtask

   task automatic t_tx_flow();
      logic [31:0] v;
      post(5, 32'hDEAD_0005);
      rd(12'h250, v); check("R5 tx status", v, 32'h0000_0020);
      rd(12'h314, v); check("R5 pointer readback", v, 32'hDEAD_0005);
      wr(12'h258, 32'h0000_FFFF);
      rd(12'h250, v); check("R8 tx clear ignored", v, 32'h0000_0020);
      rd(12'h258, v); check("R9 tx clear reads zero", v, 0);
      wr(12'h314, 32'hDEAD_0004);
      rd(12'h250, v); check("R7 mismatch keeps bit", v, 32'h0000_0020);
      check("R10 irq held", 32'(irq), 1);
      wr(12'h314, 32'hDEAD_0005);
      rd(12'h250, v); check("R6 match clears bit", v, 0);
      check("R10 irq off", 32'(irq), 0);
   endtask

   task automatic t_tx_collide();
      logic [31:0] v;
      post(2, 32'h0000_0007);
      @(negedge clk);
      port_cp_vld = 1; port_cp_q = 4'd2; port_cp_val = 32'h0000_0009;
      reg_wr = 1; reg_addr = 12'h308; reg_wdata = 32'h0000_0007;
      idle();
      rd(12'h250, v); check("R4 tx post wins", v, 32'h0000_0004);
      rd(12'h308, v); check("R4 new pointer kept", v, 32'h0000_0009);
      wr(12'h308, 32'h0000_0009);
      rd(12'h250, v); check("R6 clear after collide", v, 0);
   endtask

   task automatic t_edges();
      logic [31:0] v;
      @(negedge clk); rx_evt = '1;
      @(negedge clk); rx_evt = '0;
      rd(12'h240, v); check("R2 all rx bits, upper zero", v, 32'h0000_FFFF);
      post(15, 32'hA5A5_000F);
      rd(12'h33C, v); check("R5 last queue pointer", v, 32'hA5A5_000F);
      rd(12'h250, v); check("R5 last queue status", v, 32'h0000_8000);
      wr(12'h248, 32'h0000_FFFF);
      @(negedge clk);
      check("R11 rdata held without read", reg_rdata, 32'h0000_8000);
      rd(12'h240, v); check("R11 rdata updated by read", v, 0);
      wr(12'h33C, 32'hA5A5_000F);
      rd(12'h250, v); check("R6 last queue cleared", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_rx_set_clear();
      t_rx_collide();
      t_tx_flow();
      t_tx_collide();
      t_edges();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule